// File: doc/BRIEF.md
# Input Channel Conditioner

This block sits between a set of digital input pins and the data input register of a field-bus slave. It conditions every channel in two steps. First it applies a polarity stage, which can be set for all channels at once or for each channel on its own. Then it applies a debounce filter that can be switched on per channel. With the filter on, a level change reaches the register only after the new level has held steady for a fixed number of clocks. A short pulse, or bouncing on the line, leaves the output as it was.

The pins are assumed to be synchronized to `clk` already. The polarity and filter settings are plain static inputs. They normally come from configuration storage elsewhere in the chip. Each channel has its own stability counter. A channel starts counting when its conditioned input differs from its filtered output. It restarts from zero when the input returns to the output level. When the count completes, it takes on the new level.

Top module: `din_conditioner`

## Requirements
- R1: While `rst_n` is low, `data_o` is 4'b0000. After release, every stability counter starts idle, so a filtered channel whose input is already 1 needs the full FILTER_CYCLES rising edges before its output becomes 1.
- R2: When `inv_all_i` is 1, every channel is inverted, and the value of `inv_mask_i` has no effect.
- R3: When `inv_all_i` is 0, channel i is inverted exactly when bit i of `inv_mask_i` is 1. Bit i of each vector port belongs to channel i.
- R4: When bit i of `flt_en_i` is 0, `data_o[i]` takes the conditioned value of channel i at the next rising edge of `clk`.
- R5: When bit i of `flt_en_i` is 1, `data_o[i]` changes at the FILTER_CYCLES-th consecutive rising edge at which the conditioned input differs from `data_o[i]`, and not before. FILTER_CYCLES defaults to 16.
- R6: If a filtered channel's conditioned input returns to the output level before the count completes, the output is unchanged and the count restarts. A later change again needs FILTER_CYCLES full edges.
- R7: Each channel keeps its own counter. A change pending on one channel neither delays nor advances the change on another.
- R8: Clearing bit i of `flt_en_i` while channel i is counting makes `data_o[i]` take the conditioned value at the next rising edge.
- R9: On a filtered channel, a change of `inv_all_i` or `inv_mask_i` that alters the conditioned value is debounced in the same way as a pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | NCH | Synchronized input pins |
| inv_all_i | input | 1 | Invert all channels, overriding the mask |
| inv_mask_i | input | NCH | Per-channel invert select |
| flt_en_i | input | NCH | Per-channel debounce enable |
| data_o | output | NCH | Conditioned value for the data input register |

## Verification
The bench measures the debounce delay exactly: it looks one edge before and at the edge where a change should appear. A counter that is off by one in either direction therefore fails. It sends a pulse shorter than the filter time and then a full-length level. A counter that does not restart would let that level through early, and a counter that never clears would keep the pulse. It also staggers changes on two channels, which exposes any sharing of one counter between channels. Finally it runs the global invert with masks that disagree with it, so an override that loses to the mask shows up as wrong bits.

// File: rtl/din_conditioner.sv
module din_conditioner #(
  parameter int NCH           = 4,
  parameter int FILTER_CYCLES = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pin_i,
  input  logic           inv_all_i,
  input  logic [NCH-1:0] inv_mask_i,
  input  logic [NCH-1:0] flt_en_i,
  output logic [NCH-1:0] data_o
);

  localparam int CW = $clog2(FILTER_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(FILTER_CYCLES - 1);

  logic [NCH-1:0] cond;

  assign cond = pin_i ^ (inv_all_i ? {NCH{1'b1}} : inv_mask_i);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic          q;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q   <= 1'b0;
        cnt <= '0;
      end else if (!flt_en_i[i]) begin
        q   <= cond[i];
        cnt <= '0;
      end else if (cond[i] == q) begin
        cnt <= '0;
      end else if (cnt == LAST) begin
        q   <= cond[i];
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end

    assign data_o[i] = q;
  end

endmodule

// File: rtl/din_conditioner_chk.sv
module din_conditioner_chk #(
  parameter int NCH           = 4,
  parameter int FILTER_CYCLES = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] pin_i,
  input logic           inv_all_i,
  input logic [NCH-1:0] inv_mask_i,
  input logic [NCH-1:0] flt_en_i,
  input logic [NCH-1:0] data_o
);

  logic [NCH-1:0] want;
  assign want = inv_all_i ? ~pin_i : (pin_i ^ inv_mask_i);

  for (genvar i = 0; i < NCH; i++) begin : g_a
    a_r2_global_invert: assert property (@(posedge clk) disable iff (!rst_n)
      (!flt_en_i[i] && inv_all_i) |=> (data_o[i] == !$past(pin_i[i])));

    a_r3_mask_invert: assert property (@(posedge clk) disable iff (!rst_n)
      (!flt_en_i[i] && !inv_all_i) |=> (data_o[i] == ($past(pin_i[i]) ^ $past(inv_mask_i[i]))));

    a_r5_change_matches_input: assert property (@(posedge clk) disable iff (!rst_n)
      (data_o[i] != $past(data_o[i])) |-> (data_o[i] == $past(want[i])));

    if (FILTER_CYCLES >= 2) begin : g_stable
      a_r6_change_needs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flt_en_i[i]) && $past(flt_en_i[i], 2) && (data_o[i] != $past(data_o[i])))
          |-> (data_o[i] == $past(want[i], 2)));
    end
  end

endmodule

bind din_conditioner din_conditioner_chk #(.NCH(NCH), .FILTER_CYCLES(FILTER_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .inv_all_i(inv_all_i),
  .inv_mask_i(inv_mask_i), .flt_en_i(flt_en_i), .data_o(data_o)
);

// File: tb/test_din_conditioner.sv
`timescale 1ns/1ps
module test_din_conditioner;
  localparam int NCH = 4;
  localparam int FT  = 16;
  localparam int NV  = 9;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] pin_i = '1;
  logic           inv_all_i = 1'b0;
  logic [NCH-1:0] inv_mask_i = '0;
  logic [NCH-1:0] flt_en_i = '0;
  logic [NCH-1:0] data_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  din_conditioner #(.NCH(NCH), .FILTER_CYCLES(FT)) i_din_conditioner (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .inv_all_i(inv_all_i),
    .inv_mask_i(inv_mask_i), .flt_en_i(flt_en_i), .data_o(data_o)
  );

  // {req, pin, inv_all, mask, expected}
  localparam logic [16:0] VEC [NV] = '{
    {4'd4, 4'h0, 1'b0, 4'h0, 4'h0},  // R4
    {4'd4, 4'hA, 1'b0, 4'h0, 4'hA},  // R4
    {4'd4, 4'h5, 1'b0, 4'h0, 4'h5},  // R4
    {4'd3, 4'h0, 1'b0, 4'h1, 4'h1},  // R3
    {4'd3, 4'hF, 1'b0, 4'h8, 4'h7},  // R3
    {4'd3, 4'h6, 1'b0, 4'h5, 4'h3},  // R3
    {4'd2, 4'h0, 1'b1, 4'h0, 4'hF},  // R2
    {4'd2, 4'h3, 1'b1, 4'h5, 4'hC},  // R2
    {4'd2, 4'h9, 1'b1, 4'hF, 4'h6}   // R2
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", data_o, 4'h0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      pin_i      = VEC[k][12:9];
      inv_all_i  = VEC[k][8];
      inv_mask_i = VEC[k][7:4];
      tick(1);
      check($sformatf("R%0d", VEC[k][16:13]), data_o, VEC[k][3:0]);
    end

    pin_i = '0; inv_all_i = 1'b0; inv_mask_i = '0;
    tick(2);
    flt_en_i = '1;

    pin_i[0] = 1'b1;                                   // R5
    tick(FT - 1); check("R5", {3'b0, data_o[0]}, 4'h0);
    tick(1);      check("R5", {3'b0, data_o[0]}, 4'h1);

    pin_i[1] = 1'b1; tick(10); pin_i[1] = 1'b0;        // R6
    tick(1);      check("R6", {3'b0, data_o[1]}, 4'h0);
    pin_i[1] = 1'b1;
    tick(FT - 1); check("R6", {3'b0, data_o[1]}, 4'h0);
    tick(1);      check("R6", {3'b0, data_o[1]}, 4'h1);

    pin_i[2] = 1'b1; tick(5); pin_i[3] = 1'b1;         // R7
    tick(FT - 5); check("R7", {2'b0, data_o[3:2]}, 4'h1);
    tick(5);      check("R7", {2'b0, data_o[3:2]}, 4'h3);

    inv_mask_i = 4'h1;                                 // R9
    tick(FT - 1); check("R9", {3'b0, data_o[0]}, 4'h1);
    tick(1);      check("R9", {3'b0, data_o[0]}, 4'h0);

    pin_i[1] = 1'b0; tick(4);                          // R8
    flt_en_i[1] = 1'b0;
    tick(1);      check("R8", {3'b0, data_o[1]}, 4'h0);
    check("R8", {2'b0, data_o[3:2]}, 4'h3);

    inv_mask_i = '0; pin_i = '1; flt_en_i = '1;        // R1
    rst_n = 1'b0;
    tick(2);      check("R1", data_o, 4'h0);
    rst_n = 1'b1;
    tick(FT - 1); check("R1", data_o, 4'h0);
    tick(1);      check("R1", data_o, 4'hF);

    finish_run();
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule